// File: doc/BRIEF.md
# Nibble-Pair Indirect Memory Access Unit

This unit moves and compares whole bytes against a data memory whose words are only four bits wide. A request supplies an 8-bit pointer, a bank-enable flag, a bank-select value and the current 8-bit accumulator. The unit clears the pointer's least significant bit to form an even address and puts the effective bank in front of it. It then treats the nibble at that even address and the nibble at the next address as one byte.

Four operations are supported. Load copies the memory byte into the accumulator. Store writes the accumulator into the nibble pair. Exchange swaps the two atomically. Compare-and-skip raises a skip flag when the accumulator equals the memory byte, and changes neither side. Each access takes two memory cycles, one per nibble, and then a result cycle. Completion is marked by a one-cycle done pulse, together with the resulting accumulator value. The unit accepts a new request only while it is idle.

Top module: `npa_unit`

## Requirements
- R1: Bit 0 of `ptr_i` has no effect: pointers 2k and 2k+1 access the same nibble pair, including the pair at pointer FEH/FFH.
- R2: The low accumulator nibble (`acc[3:0]`) lives at the even address and the high nibble (`acc[7:4]`) at the even address plus one. A store to one pair leaves the neighbouring pairs unchanged.
- R3: The effective bank is `bank_sel_i` when `bank_en_i` is 1 and bank 0 when `bank_en_i` is 0. With the enable at 0, the select value has no effect.
- R4: Operation code 0 (load) returns the 8-bit memory pair on `acc_o` and leaves memory unchanged.
- R5: Operation code 1 (store) writes `acc_i` into the pair and returns `acc_i` unchanged on `acc_o`.
- R6: Operation code 2 (exchange) returns the old memory pair on `acc_o` and leaves the old `acc_i` in memory.
- R7: Operation code 3 (compare) drives `skip_o` high in the done cycle when `acc_i` equals the pair, and low otherwise. It writes no memory, returns `acc_i` on `acc_o`, and `skip_o` is never high outside a done cycle.
- R8: `done_o` is high for exactly one cycle. It rises on the fourth rising edge counted from, and including, the edge that accepts the request. `acc_o` and `skip_o` are valid in that cycle.
- R9: `ready_o` is low from acceptance until the done cycle. A request presented while `ready_o` is low is ignored and makes no memory access.
- R10: After reset `ready_o` is 1 and `done_o`, `skip_o` and `acc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request, taken when ready_o is high |
| op_i | input | 2 | 0 load, 1 store, 2 exchange, 3 compare |
| ptr_i | input | 8 | Nibble pointer; bit 0 is ignored |
| bank_en_i | input | 1 | Bank-enable flag |
| bank_sel_i | input | BANK_W | Bank-select value |
| acc_i | input | 8 | Accumulator value before the operation |
| ready_o | output | 1 | Unit idle, request can be taken |
| done_o | output | 1 | One-cycle completion pulse |
| skip_o | output | 1 | Compare matched (valid with done_o) |
| acc_o | output | 8 | Accumulator value after the operation |

## Verification
The end of one access and the acceptance of the next can fall in the same cycle, because `ready_o` returns high together with `done_o`. The bench provokes this by presenting each new request at the same falling edge where it has just sampled the previous done pulse. It then judges that the next done pulse arrives at the normal latency and carries that request's own result. In particular, a load that follows a matching compare back-to-back must report no skip. A separate case presents a store while the unit is busy, and checks through a later load that the store never reached memory.

// File: rtl/npa_pkg.sv
package npa_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_XCH   = 2'd2,
    OP_CMP   = 2'd3
  } npa_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_FIN  = 2'd3
  } npa_state_e;
endpackage

// File: rtl/npa_addr_gen.sv
module npa_addr_gen #(
  parameter int PTR_W  = 8,
  parameter int BANK_W = 2,
  localparam int ADDR_W = BANK_W + PTR_W
) (
  input  logic [PTR_W-1:1]  ptr_hi_i,
  input  logic              bank_en_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic              odd_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [BANK_W-1:0] bank_eff;

  for (genvar g = 0; g < BANK_W; g++) begin : g_bank
    assign bank_eff[g] = bank_sel_i[g] & bank_en_i;
  end

  assign addr_o = {bank_eff, ptr_hi_i, odd_i};
endmodule

// File: rtl/npa_nibble_ram.sv
module npa_nibble_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // read-first: rdata_o returns the value before this cycle's write
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/npa_ctrl.sv
module npa_ctrl
  import npa_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  npa_op_e op_i,
  output logic    ready_o,
  output logic    accept_o,
  output logic    in_lo_o,
  output logic    in_hi_o,
  output logic    in_fin_o,
  output logic    mem_we_o
);
  npa_state_e state_q, state_d;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept_o = req_i & ready_o;
  assign in_lo_o  = (state_q == ST_LO);
  assign in_hi_o  = (state_q == ST_HI);
  assign in_fin_o = (state_q == ST_FIN);
  assign mem_we_o = (in_lo_o | in_hi_o) & ((op_i == OP_STORE) | (op_i == OP_XCH));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_i) state_d = ST_LO;
      ST_LO:   state_d = ST_HI;
      ST_HI:   state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/npa_unit.sv
module npa_unit
  import npa_pkg::*;
#(
  parameter int PTR_W  = 8,
  parameter int BANK_W = 2,
  parameter int NIB_W  = 4,
  localparam int ADDR_W = BANK_W + PTR_W,
  localparam int BYTE_W = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              bank_en_i,
  input  logic [BANK_W-1:0] bank_sel_i,
  input  logic [BYTE_W-1:0] acc_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              skip_o,
  output logic [BYTE_W-1:0] acc_o
);
  npa_op_e           op_q;
  logic [PTR_W-1:1]  ptr_q;
  logic              en_q;
  logic [BANK_W-1:0] sel_q;
  logic [BYTE_W-1:0] acc_q;
  logic [NIB_W-1:0]  lo_q;
  logic [BYTE_W-1:0] acc_r;
  logic              done_r, skip_r;

  logic              accept, in_lo, in_hi, in_fin, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [NIB_W-1:0]  mem_wd, mem_rd;
  logic [BYTE_W-1:0] mem_byte;
  logic              unused_ptr_lsb;

  assign unused_ptr_lsb = ptr_i[0];

  npa_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .op_i    (op_q),
    .ready_o (ready_o),
    .accept_o(accept),
    .in_lo_o (in_lo),
    .in_hi_o (in_hi),
    .in_fin_o(in_fin),
    .mem_we_o(mem_we)
  );

  npa_addr_gen #(.PTR_W(PTR_W), .BANK_W(BANK_W)) u_addr (
    .ptr_hi_i  (ptr_q),
    .bank_en_i (en_q),
    .bank_sel_i(sel_q),
    .odd_i     (in_hi),
    .addr_o    (mem_addr)
  );

  assign mem_wd = in_hi ? acc_q[BYTE_W-1:NIB_W] : acc_q[NIB_W-1:0];

  npa_nibble_ram #(.ADDR_W(ADDR_W), .DATA_W(NIB_W)) u_ram (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .addr_i (mem_addr),
    .wdata_i(mem_wd),
    .rdata_o(mem_rd)
  );

  // request capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_LOAD;
      ptr_q <= '0;
      en_q  <= 1'b0;
      sel_q <= '0;
      acc_q <= '0;
    end else if (accept) begin
      op_q  <= npa_op_e'(op_i);
      ptr_q <= ptr_i[PTR_W-1:1];
      en_q  <= bank_en_i;
      sel_q <= bank_sel_i;
      acc_q <= acc_i;
    end
  end

  // even nibble arrives during ST_HI
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lo_q <= '0;
    else if (in_hi) lo_q <= mem_rd;
  end

  assign mem_byte = {mem_rd, lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_r  <= '0;
      done_r <= 1'b0;
      skip_r <= 1'b0;
    end else begin
      done_r <= in_fin;
      skip_r <= in_fin && (op_q == OP_CMP) && (mem_byte == acc_q);
      if (in_fin) begin
        unique case (op_q)
          OP_LOAD, OP_XCH: acc_r <= mem_byte;
          default:         acc_r <= acc_q;
        endcase
      end
    end
  end

  assign done_o = done_r;
  assign skip_o = skip_r;
  assign acc_o  = acc_r;
endmodule

// File: rtl/npa_unit_chk.sv
module npa_unit_chk #(
  parameter int PTR_W  = 8,
  parameter int BANK_W = 2,
  parameter int NIB_W  = 4,
  localparam int ADDR_W = BANK_W + PTR_W,
  localparam int BYTE_W = 2 * NIB_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              done_o,
  input logic              skip_o,
  input logic              in_lo,
  input logic              in_hi,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [NIB_W-1:0]  mem_wd,
  input logic [BYTE_W-1:0] acc_q,
  input logic              en_q,
  input logic [1:0]        op_q
);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!$past(ready_o, 1) && !$past(ready_o, 2) && !$past(ready_o, 3)));

  // R7
  skip_in_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> done_o);

  // R9
  busy_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(req_i));

  // R2
  even_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && in_lo) |-> (!mem_addr[0] && mem_wd == acc_q[NIB_W-1:0]));

  // R2
  odd_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && in_hi) |-> (mem_addr[0] && mem_wd == acc_q[BYTE_W-1:NIB_W]));

  // R3
  bank_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((in_lo || in_hi) && !en_q) |-> (mem_addr[ADDR_W-1:PTR_W] == '0));

  // R7
  cmp_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == 2'd3) |-> !mem_we);

  // R9
  idle_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_we);
endmodule

bind npa_unit npa_unit_chk #(.PTR_W(PTR_W), .BANK_W(BANK_W), .NIB_W(NIB_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .ready_o (ready_o),
  .done_o  (done_o),
  .skip_o  (skip_o),
  .in_lo   (in_lo),
  .in_hi   (in_hi),
  .mem_we  (mem_we),
  .mem_addr(mem_addr),
  .mem_wd  (mem_wd),
  .acc_q   (acc_q),
  .en_q    (en_q),
  .op_q    (op_q)
);

// File: tb/npa_unit_test.sv
module npa_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic [1:0] op = '0;
  logic [7:0] ptr = '0;
  logic       en = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] acc_in = '0;
  logic       ready, done, skip;
  logic [7:0] acc_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  npa_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .ptr_i(ptr),
    .bank_en_i(en), .bank_sel_i(sel), .acc_i(acc_in),
    .ready_o(ready), .done_o(done), .skip_o(skip), .acc_o(acc_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // entered at a falling edge; returns at the falling edge where done_o is high
  task automatic run_op(input logic [1:0] o, input logic [7:0] p, input logic e,
                        input logic [1:0] s, input logic [7:0] a,
                        output logic [7:0] r_acc, output logic r_skip, output int lat);
    int guard = 0;
    while (!ready && guard < 50) begin @(negedge clk); guard++; end
    op = o; ptr = p; en = e; sel = s; acc_in = a; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    r_acc = acc_out;
    r_skip = skip;
  endtask

  // tag, op, ptr, en, sel, acc_in, exp_acc, exp_skip
  localparam int NV = 15;
  localparam logic [33:0] VEC [NV] = '{
    {4'd5, 2'd1, 8'h10, 1'b0, 2'd0, 8'hA5, 8'hA5, 1'b0},  // R5 store bank 0
    {4'd1, 2'd0, 8'h11, 1'b0, 2'd3, 8'h00, 8'hA5, 1'b0},  // R1 odd ptr, R3 sel ignored
    {4'd5, 2'd1, 8'h10, 1'b1, 2'd2, 8'h3C, 8'h3C, 1'b0},  // R5 store bank 2
    {4'd4, 2'd0, 8'h10, 1'b1, 2'd2, 8'h00, 8'h3C, 1'b0},  // R4 load bank 2
    {4'd3, 2'd0, 8'h10, 1'b1, 2'd0, 8'hFF, 8'hA5, 1'b0},  // R3 bank 0 intact
    {4'd6, 2'd2, 8'h10, 1'b1, 2'd2, 8'h96, 8'h3C, 1'b0},  // R6 exchange
    {4'd6, 2'd0, 8'h11, 1'b1, 2'd2, 8'h00, 8'h96, 1'b0},  // R6 memory took old acc
    {4'd7, 2'd3, 8'h10, 1'b1, 2'd2, 8'h96, 8'h96, 1'b1},  // R7 equal
    {4'd7, 2'd3, 8'h10, 1'b1, 2'd2, 8'h69, 8'h69, 1'b0},  // R7 nibbles swapped
    {4'd7, 2'd0, 8'h10, 1'b1, 2'd2, 8'h00, 8'h96, 1'b0},  // R7 compare wrote nothing
    {4'd5, 2'd1, 8'hFE, 1'b1, 2'd1, 8'h12, 8'h12, 1'b0},  // R5 top pair
    {4'd1, 2'd0, 8'hFF, 1'b1, 2'd1, 8'h00, 8'h12, 1'b0},  // R1 ptr FF
    {4'd5, 2'd1, 8'h12, 1'b0, 2'd0, 8'h7E, 8'h7E, 1'b0},  // R5 neighbour pair
    {4'd2, 2'd0, 8'h10, 1'b0, 2'd0, 8'h00, 8'hA5, 1'b0},  // R2 neighbour unchanged
    {4'd2, 2'd0, 8'h13, 1'b0, 2'd0, 8'h00, 8'h7E, 1'b0}   // R2 new pair
  };

  initial begin : watchdog
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<20000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] r_acc;
    logic r_skip;
    int lat;

    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 ready", int'(ready), 1);
    check("R10 done", int'(done), 0);
    check("R10 skip", int'(skip), 0);
    check("R10 acc", int'(acc_out), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // back-to-back: each request is driven in the previous done cycle
    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      v = VEC[i];
      run_op(v[29:28], v[27:20], v[19], v[18:17], v[16:9], r_acc, r_skip, lat);
      check($sformatf("R%0d vec%0d acc", v[33:30], i), int'(r_acc), int'(v[8:1]));
      check($sformatf("R%0d vec%0d skip", v[33:30], i), int'(r_skip), int'(v[0]));
      check($sformatf("R8 vec%0d latency", i), lat, 4);
    end

    // R7 skip does not leak into the following access
    run_op(2'd3, 8'h10, 1'b1, 2'd2, 8'h96, r_acc, r_skip, lat);
    check("R7 match", int'(r_skip), 1);
    run_op(2'd0, 8'h12, 1'b0, 2'd0, 8'h00, r_acc, r_skip, lat);
    check("R7 next skip", int'(r_skip), 0);
    check("R4 next acc", int'(r_acc), 8'h7E);
    @(negedge clk);
    check("R8 done one cycle", int'(done), 0);
    check("R7 skip outside done", int'(skip), 0);

    // R9 request during busy is ignored
    run_op(2'd1, 8'h20, 1'b0, 2'd0, 8'h11, r_acc, r_skip, lat);
    @(negedge clk);
    op = 2'd0; ptr = 8'h10; en = 1'b0; sel = 2'd0; acc_in = 8'h00; req = 1'b1;
    @(negedge clk);
    check("R9 ready low", int'(ready), 0);
    op = 2'd1; ptr = 8'h20; acc_in = 8'h55; req = 1'b1;
    @(negedge clk);
    check("R9 still busy", int'(ready), 0);
    req = 1'b0;
    while (!done) @(negedge clk);
    check("R9 first result", int'(acc_out), 8'hA5);
    @(negedge clk);
    check("R9 idle after", int'(ready), 1);
    run_op(2'd0, 8'h21, 1'b0, 2'd0, 8'h00, r_acc, r_skip, lat);
    check("R9 busy store ignored", int'(r_acc), 8'h11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule